// File: doc/BRIEF.md
# Lattice-Ladder Recursive Filter (Q1.15)

This block filters a stream of signed 16-bit Q1.15 samples through an all-pole lattice of `STAGES` sections followed by a ladder (tap-weighted) output sum. The number of sections is fixed when the block is elaborated and must not exceed `MAX_STAGES`. One arithmetic cell is shared by all sections. It is stepped once per clock from the top section (gain index 0) down to the bottom section (index `STAGES-1`). One extra clock then adds the final ladder term, and the block presents a single output sample.

The coefficient set has two parts. There are `STAGES` reflection gains and `STAGES+1` tap weights, all Q1.15 and all writable through a plain address/data port. The block also keeps `STAGES` delayed backward-path words as its recursive state. A synchronous clear zeroes that state and leaves the coefficients untouched.

The input is a valid/ready stream. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low for the whole computation, so an upstream source is held back until the result has been produced. The output side has no back-pressure. `out_valid` is a one-cycle strobe, and a consumer must capture `out_data` in that cycle or later, before the next strobe.

Top module: `lattice_ladder_iir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and all coefficients and state words are zero, so any sample yields a zero output until weights are written.
- R2: A sample accepted at clock edge E yields `out_valid` high for exactly one cycle, starting at edge E+STAGES+1. `in_ready` is low from edge E+1 until that same edge and is high again in the cycle where `out_valid` is high.
- R3: For section i, the next forward value is sat16(f − ((k[i]·s[i]) >>> 15)), where s[i] is that section's delayed state from the previous sample and the input sample is the forward value entering section 0.
- R4: For section i, the backward value is sat16(((k[i]·f') >>> 15) + s[i]), where f' is the saturated forward value just produced by that section.
- R5: Every backward value b[i] is multiplied by tap weight w[i], and the full 32-bit product is summed in a 64-bit accumulator that is cleared for each sample. The last forward value times w[STAGES] is then added. The output is sat16(acc >>> 15), truncating toward minus infinity with no rounding.
- R6: After an output is produced, the state becomes s[i] = b[i+1] for i < STAGES−1 and s[STAGES−1] = final forward value. During the computation, every section reads only the previous sample's state.
- R7: When `cfg_we` is high at an edge while the block is idle, `cfg_addr` in 0..STAGES−1 writes reflection gain k[addr], and `cfg_addr` in STAGES..2·STAGES writes tap weight w[addr−STAGES]. Writes at larger addresses, or while a sample is being processed, change nothing.
- R8: `clr` high at an edge zeroes all state words, keeps every coefficient, and abandons any sample in progress without producing an output. `in_ready` is low while `clr` is high.
- R9: `out_data` holds its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| clr | input | 1 | Synchronous state clear; also aborts a sample in progress |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample, Q1.15 |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | 16 | Output sample, Q1.15 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | $clog2(2·STAGES+1) | Coefficient address (gains, then weights) |
| cfg_data | input | 16 | Coefficient value, Q1.15 |

## Verification
With all reflection gains at zero, the lattice turns into a pure delay line. An impulse then shows the tap weights in order, which isolates the state shift and the tap indexing from the recursion. Random gains and samples, run against an independent reference, test the two saturating section equations together with the accumulation. Full-scale gains, weights and samples drive every saturation point, and a tiny negative sum checks that the output shift truncates instead of rounding. Writes issued while busy, writes to unused addresses, and a clear that arrives mid-sample or while idle each leave a mark on the samples that follow, so their handling can be checked.

// File: rtl/iirl_pkg.sv
package iirl_pkg;
  localparam int SW    = 16;
  localparam int PW    = 2 * SW;
  localparam int ACC_W = 64;

  typedef logic signed [SW-1:0]    q15_t;
  typedef logic signed [PW-1:0]    prod_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic prod_t ext16(input q15_t a);
    return {{(PW-SW){a[SW-1]}}, a};
  endfunction

  function automatic acc_t ext32(input prod_t a);
    return {{(ACC_W-PW){a[PW-1]}}, a};
  endfunction

  function automatic q15_t sat16(input acc_t x);
    if (x > acc_t'(32767))       return 16'sh7fff;
    else if (x < -acc_t'(32768)) return 16'sh8000;
    else                         return x[SW-1:0];
  endfunction
endpackage

// File: rtl/lattice_cell.sv
module lattice_cell
  import iirl_pkg::*;
(
  input  q15_t f_in,
  input  q15_t s_in,
  input  q15_t k,
  input  q15_t w,
  input  acc_t acc_in,
  output q15_t f_out,
  output q15_t b_out,
  output acc_t acc_out
);
  prod_t p_ks, p_kf, p_bw;
  acc_t  f_wide, b_wide;

  always_comb begin
    p_ks    = ext16(k) * ext16(s_in);
    f_wide  = ext32(ext16(f_in)) - ext32(p_ks >>> 15);
    f_out   = sat16(f_wide);
    p_kf    = ext16(k) * ext16(f_out);
    b_wide  = ext32(p_kf >>> 15) + ext32(ext16(s_in));
    b_out   = sat16(b_wide);
    p_bw    = ext16(b_out) * ext16(w);
    acc_out = acc_in + ext32(p_bw);
  end
endmodule

// File: rtl/lattice_coefs.sv
module lattice_coefs
  import iirl_pkg::*;
#(
  parameter  int STAGES = 4,
  localparam int ADDR_W = $clog2(2 * STAGES + 1),
  localparam int IDX_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  q15_t              wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output q15_t              k_sel,
  output q15_t              w_sel,
  output q15_t              w_last
);
  q15_t [STAGES-1:0] gain_q;
  q15_t [STAGES:0]   wt_q;
  logic              wr_ok;

  assign wr_ok = wr_en && idle;

  for (genvar i = 0; i < STAGES; i++) begin : g_gain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gain_q[i] <= '0;
      else if (wr_ok && wr_addr == ADDR_W'(i)) gain_q[i] <= wr_data;
    end
  end

  for (genvar j = 0; j <= STAGES; j++) begin : g_wt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wt_q[j] <= '0;
      else if (wr_ok && wr_addr == ADDR_W'(STAGES + j)) wt_q[j] <= wr_data;
    end
  end

  assign k_sel  = gain_q[rd_idx];
  assign w_sel  = wt_q[rd_idx];
  assign w_last = wt_q[STAGES];

  // R7: coefficients are frozen while a sample is in flight
  a_r7_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(gain_q) && $stable(wt_q)));
endmodule

// File: rtl/lattice_state.sv
module lattice_state
  import iirl_pkg::*;
#(
  parameter  int STAGES = 4,
  localparam int IDX_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  q15_t             b_val,
  input  logic             commit,
  input  q15_t             f_final,
  input  logic [IDX_W-1:0] rd_idx,
  output q15_t             s_sel
);
  q15_t [STAGES-1:0] st_q;

  if (STAGES > 1) begin : g_multi
    // pend_q[i] holds the backward value of section i+1 until commit
    q15_t [STAGES-2:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= '0;
        pend_q <= '0;
      end else if (clr) begin
        st_q   <= '0;
        pend_q <= '0;
      end else begin
        if (b_we && b_idx != '0) pend_q[b_idx - 1'b1] <= b_val;
        if (commit) st_q <= {f_final, pend_q};
      end
    end

    // R6: section 0 inherits the backward value of section 1
    a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !clr) |=> (st_q[0] == $past(pend_q[0])));
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= '0;
      else if (clr)    st_q <= '0;
      else if (commit) st_q[0] <= f_final;
    end
  end

  assign s_sel = st_q[rd_idx];

  // R6: bottom state takes the final forward value
  a_r6_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clr) |=> (st_q[STAGES-1] == $past(f_final)));
  // R8: clear empties every state word
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == '0));
endmodule

// File: rtl/lattice_ladder_iir.sv
module lattice_ladder_iir
  import iirl_pkg::*;
#(
  parameter  int STAGES     = 4,
  parameter  int MAX_STAGES = 16,
  localparam int ADDR_W     = $clog2(2 * STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  output logic              out_valid,
  output logic [15:0]       out_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_data
);
  localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STAGES - 1);

  if (STAGES < 1 || STAGES > MAX_STAGES) begin : g_bad_cfg
    $error("lattice_ladder_iir: STAGES out of range");
  end

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FINISH} phase_e;

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  q15_t             f_q, out_q;
  acc_t             acc_q, acc_fin;
  logic             ovalid_q;
  q15_t             k_sel, w_sel, w_last, s_sel;
  q15_t             f_nx, b_nx;
  acc_t             acc_nx;
  prod_t            p_last;
  logic             idle, run, commit;

  assign idle     = (phase_q == S_IDLE);
  assign run      = (phase_q == S_RUN) && !clr;
  assign commit   = (phase_q == S_FINISH) && !clr;
  assign in_ready = idle && !clr;

  lattice_coefs #(.STAGES(STAGES)) u_coefs (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .rd_idx(idx_q), .k_sel(k_sel), .w_sel(w_sel), .w_last(w_last)
  );

  lattice_state #(.STAGES(STAGES)) u_state (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .b_we(run), .b_idx(idx_q), .b_val(b_nx),
    .commit(commit), .f_final(f_q),
    .rd_idx(idx_q), .s_sel(s_sel)
  );

  lattice_cell u_cell (
    .f_in(f_q), .s_in(s_sel), .k(k_sel), .w(w_sel), .acc_in(acc_q),
    .f_out(f_nx), .b_out(b_nx), .acc_out(acc_nx)
  );

  always_comb begin
    p_last  = ext16(f_q) * ext16(w_last);
    acc_fin = acc_q + ext32(p_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= S_IDLE;
      idx_q    <= '0;
      f_q      <= '0;
      acc_q    <= '0;
      out_q    <= '0;
      ovalid_q <= 1'b0;
    end else begin
      ovalid_q <= 1'b0;
      if (clr) begin
        phase_q <= S_IDLE;
        idx_q   <= '0;
      end else begin
        unique case (phase_q)
          S_IDLE: if (in_valid) begin
            f_q     <= in_data;
            acc_q   <= '0;
            idx_q   <= '0;
            phase_q <= S_RUN;
          end
          S_RUN: begin
            f_q   <= f_nx;
            acc_q <= acc_nx;
            if (idx_q == LAST_IDX) phase_q <= S_FINISH;
            else                   idx_q   <= idx_q + 1'b1;
          end
          S_FINISH: begin
            out_q    <= sat16(acc_fin >>> 15);
            ovalid_q <= 1'b1;
            idx_q    <= '0;
            phase_q  <= S_IDLE;
          end
          default: phase_q <= S_IDLE;
        endcase
      end
    end
  end

  assign out_valid = ovalid_q;
  assign out_data  = out_q;

  // R2: output strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2: an accepted sample blocks further input
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R2: ready returns together with the output strobe
  a_r2_ready_with_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !clr) |-> in_ready);
  // R8: no acceptance while clearing
  a_r8_no_ready_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);
  // R9: output data holds between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/sim_lattice_ladder_iir.sv
module sim_lattice_ladder_iir;
  localparam int N  = 4;
  localparam int AW = $clog2(2 * N + 1);

  logic          clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic          in_valid = 1'b0, cfg_we = 1'b0;
  logic [15:0]   in_data = '0, cfg_data = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic          in_ready, out_valid;
  logic [15:0]   out_data;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int km[N], wm[N+1], sm[N];
  int exp_q[$], cyc_q[$];

  lattice_ladder_iir #(.STAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bsat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // reference model: one sample through sections, ladder and state update
  function automatic int model_step(int x);
    int f = x, fn, bn;
    int b[N];
    longint acc = 0;
    for (int i = 0; i < N; i++) begin
      fn = bsat(longint'(f) - longint'((km[i] * sm[i]) >>> 15));
      bn = bsat(longint'((km[i] * fn) >>> 15) + longint'(sm[i]));
      acc += longint'(bn) * longint'(wm[i]);
      b[i] = bn;
      f = fn;
    end
    acc += longint'(f) * longint'(wm[N]);
    for (int i = 0; i < N - 1; i++) sm[i] = b[i+1];
    sm[N-1] = f;
    return bsat(acc >>> 15);
  endfunction

  // driver: offers a sample, pushes the expected result to the scoreboard
  task automatic send(int x, bit expect_out);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    if (expect_out) begin
      exp_q.push_back(model_step(x));
      cyc_q.push_back(cyc + 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready-low-after-accept", int'(in_ready), 0);
  endtask

  task automatic wr(int addr, int val);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = 16'(val);
    if (in_ready) begin
      if (addr < N) km[addr] = val;
      else if (addr <= 2 * N) wm[addr - N] = val;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each strobe against the scoreboard
  bit prev_v = 0;
  int last_out = 0;
  always @(negedge clk) if (rst_n && !finished) begin
    if (out_valid) begin
      check(!prev_v, "R2 one-cycle-strobe", int'(prev_v), 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected-output", int'($signed(out_data)), 0);
      end else begin
        int e, c;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        check(int'($signed(out_data)) == e, "R5 output (R3 R4 R6)", int'($signed(out_data)), e);
        check(cyc - c == N + 1, "R2 latency", cyc - c, N + 1);
        check(in_ready == 1'b1, "R2 ready-with-strobe", int'(in_ready), 1);
      end
      last_out = int'($signed(out_data));
    end else if (int'($signed(out_data)) != last_out) begin
      check(1'b0, "R9 hold", int'($signed(out_data)), last_out);
    end
    prev_v = out_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin km[i] = 0; sm[i] = 0; end
    for (int i = 0; i <= N; i++) wm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 16'd0, "R1 out_data", int'(out_data), 0);
    // R1 zero coefficients give zero output
    send(12000, 1); send(-20000, 1); drain();

    // R7 delay-line pattern: zero gains, distinct weights, impulse
    for (int i = 0; i <= N; i++) wr(N + i, 4000 * (i + 1));
    send(32767, 1);
    for (int i = 0; i < N + 2; i++) send(0, 1);
    drain();

    // R3 R4 R5 random gains and samples
    for (int i = 0; i < N; i++) wr(i, int'($urandom_range(0, 58000)) - 29000);
    for (int i = 0; i <= N; i++) wr(N + i, int'($urandom_range(0, 40000)) - 20000);
    for (int s = 0; s < 40; s++) send(int'($urandom_range(0, 65535)) - 32768, 1);
    drain();

    // R7 write while busy is ignored; out-of-range addresses ignored
    send(1500, 1);
    wr(0, 31000); wr(N, -31000);
    drain();
    for (int a = 2 * N + 1; a < (1 << AW); a++) wr(a, 12345);
    for (int s = 0; s < 6; s++) send(int'($urandom_range(0, 65535)) - 32768, 1);
    drain();

    // R3 R4 saturation: full-scale gains, weights, samples
    for (int i = 0; i < N; i++) wr(i, 32767);
    for (int i = 0; i <= N; i++) wr(N + i, (i % 2 == 0) ? 32767 : -32768);
    for (int s = 0; s < 12; s++) send((s % 3 == 0) ? -32768 : 32767, 1);
    drain();

    // R8 clear mid-sample aborts and zeroes state, coefficients kept
    send(9000, 0);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < N; i++) sm[i] = 0;
    repeat (N + 3) @(negedge clk);
    send(-7000, 1); send(3000, 1); drain();
    // R8 clear while idle
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    for (int i = 0; i < N; i++) sm[i] = 0;
    send(-7000, 1); drain();

    // R5 truncation: tiny final weight, no rounding
    for (int i = 0; i < N; i++) wr(i, 0);
    for (int i = 0; i <= N; i++) wr(N + i, (i == N) ? 1 : 0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    for (int i = 0; i < N; i++) sm[i] = 0;
    send(-1, 1); drain();
    check(int'($signed(out_data)) == -1, "R5 truncate-negative", int'($signed(out_data)), -1);
    send(1, 1); drain();
    check(int'($signed(out_data)) == 0, "R5 truncate-positive", int'($signed(out_data)), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule